// File: doc/BRIEF.md
# Address Range Guard

The guard checks the address of every bus access against six programmable address windows. Each window has its own read permission and its own write permission. An access that falls in no window is judged by a global read bit or a global write bit. When an access is not permitted and the guard is enabled, it records the offending address and raises a read-violation flag or a write-violation flag. Only the first offence is recorded. Software reads the record and clears the flag through a small register port.

Each window is an aligned base plus a power-of-two size code. Codes 9 to 21 give sizes from 512 bytes to 2 MB. The low `code` bits of the base are ignored, so a window always starts on a multiple of its own size. A test mode lets software send an address through the same checker by writing a register. This exercises the violation path without any bus traffic. The guard does not stop the bus cycle and does not translate addresses.

Top module: `addr_guard`

## Requirements
- R1: After reset both violation flags are 0 and every register select (0 to 8) reads back 0.
- R2: Register selects are 0 = control, 1..6 = windows 0..5, 7 = captured address, 8 = test. A window register keeps base bits 31:9 and size code bits 4:0, and bits 8:5 read as 0. The control register keeps only bits 31, 30, 19, 15:10, 9 and 5:0; all other bits read as 0.
- R3: A window with code c in 9..21 matches an address when the address and the base agree in bits 31:c. Any other code (0, 1..8, 22..31) matches nothing.
- R4: Control bit i (0..5) permits writes to window i, and control bit 10+i permits reads from it. An access is allowed if any matching window permits its direction. If no window matches, bit 9 decides writes and bit 19 decides reads.
- R5: With control bit 31 set, a disallowed access strobe acts one clock later. A read sets rd_viol, a write sets wr_viol, and the address is captured and readable at select 7.
- R6: While either flag is set, no new violation is recorded and the captured address holds. At most one flag is set at a time.
- R7: A register write to select 7 clears rd_viol when data bit 0 is 1 and clears wr_viol when data bit 1 is 1. A violation in the same cycle is judged after the clear.
- R8: With control bit 31 clear, no flag is raised and the captured address is unchanged.
- R9: A write to select 8 while bits 31 and 30 are both set is checked as an access: the address is data bits 31:2 with bits 1:0 zero, and the direction is data bit 0 (1 = write). With bit 30 clear the write has no effect. A bus strobe in the same cycle takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Bus access strobe |
| acc_write | input | 1 | Access direction, 1 = write |
| acc_addr | input | 32 | Access byte address |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 4 | Register select |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Read data of the selected register |
| rd_viol | output | 1 | Read violation flag |
| wr_viol | output | 1 | Write violation flag |

## Verification
The assertions assume that inputs are stable and known from the first clock after reset. They also assume that a clear write to select 7 and a test write to select 8 never happen in the same cycle, which the single select port guarantees. The properties on captured addresses further assume that a bus strobe always wins over a test write. The bench drives every input at the falling edge from a reference model. Its random phase keeps window codes mostly in the valid range and aims addresses near each programmed base, so that matches, misses and overlaps all occur.

// File: rtl/guard_pkg.sv
package guard_pkg;
  localparam int ADDR_W   = 32;
  localparam int BASE_LSB = 9;
  localparam int CODE_W   = 5;
  localparam int BASE_W   = ADDR_W - BASE_LSB;
  // control word bit positions; software relies on these
  localparam int EN_BIT   = 31;
  localparam int TEST_BIT = 30;
  localparam int GRD_BIT  = 19;
  localparam int GWR_BIT  = 9;
  localparam int RD_LSB   = 10;
  localparam int WR_LSB   = 0;

  typedef struct packed {
    logic              valid;
    logic              is_write;
    logic [ADDR_W-1:0] addr;
  } probe_t;
endpackage

// File: rtl/guard_regs.sv
module guard_regs
  import guard_pkg::*;
#(
  parameter int NUM_RANGES = 6,
  parameter int SEL_W      = 4
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                cfg_we,
  input  logic [SEL_W-1:0]                    cfg_sel,
  input  logic [ADDR_W-1:0]                   cfg_wdata,
  input  logic [ADDR_W-1:0]                   vaddr,
  output logic [ADDR_W-1:0]                   ctrl_q,
  output logic [NUM_RANGES-1:0][BASE_W-1:0]   base_q,
  output logic [NUM_RANGES-1:0][CODE_W-1:0]   code_q,
  output logic [ADDR_W-1:0]                   cfg_rdata
);
  localparam logic [ADDR_W-1:0] ONE        = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] RANGE_BITS = (ONE << NUM_RANGES) - ONE;
  localparam logic [ADDR_W-1:0] CTRL_MASK  = (ONE << EN_BIT) | (ONE << TEST_BIT) |
                                             (ONE << GRD_BIT) | (ONE << GWR_BIT) |
                                             (RANGE_BITS << RD_LSB) | (RANGE_BITS << WR_LSB);
  localparam logic [SEL_W-1:0]  SEL_CTRL   = '0;
  localparam logic [SEL_W-1:0]  SEL_VADDR  = SEL_W'(NUM_RANGES + 1);
  localparam int                GAP_W      = BASE_LSB - CODE_W;

  logic                  ctrl_we;
  logic [ADDR_W-1:0]     ctrl_d;
  logic [NUM_RANGES-1:0] rng_we;

  // next-state
  always_comb begin
    ctrl_we = cfg_we && (cfg_sel == SEL_CTRL);
    ctrl_d  = cfg_wdata & CTRL_MASK;
    for (int i = 0; i < NUM_RANGES; i++) begin
      rng_we[i] = cfg_we && (cfg_sel == SEL_W'(i + 1));
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (ctrl_we) begin
      ctrl_q <= ctrl_d;
    end
  end

  for (genvar g = 0; g < NUM_RANGES; g++) begin : g_win
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_q[g] <= '0;
        code_q[g] <= '0;
      end else if (rng_we[g]) begin
        base_q[g] <= cfg_wdata[ADDR_W-1:BASE_LSB];
        code_q[g] <= cfg_wdata[CODE_W-1:0];
      end
    end
  end

  // read mux
  always_comb begin
    cfg_rdata = '0;
    if (cfg_sel == SEL_CTRL) cfg_rdata = ctrl_q;
    for (int i = 0; i < NUM_RANGES; i++) begin
      if (cfg_sel == SEL_W'(i + 1)) cfg_rdata = {base_q[i], {GAP_W{1'b0}}, code_q[i]};
    end
    if (cfg_sel == SEL_VADDR) cfg_rdata = vaddr;
  end
endmodule

// File: rtl/guard_range_cmp.sv
module guard_range_cmp
  import guard_pkg::*;
#(
  parameter int CODE_MIN = 9,
  parameter int CODE_MAX = 21
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [BASE_W-1:0] base,
  input  logic [CODE_W-1:0] code,
  output logic              hit
);
  logic              code_ok;
  logic [ADDR_W-1:0] keep_mask;
  logic [ADDR_W-1:0] diff;

  always_comb begin
    code_ok   = (code >= CODE_W'(CODE_MIN)) && (code <= CODE_W'(CODE_MAX));
    keep_mask = {ADDR_W{1'b1}} << code;
    diff      = addr ^ {base, {BASE_LSB{1'b0}}};
    hit       = code_ok && ((diff & keep_mask) == '0);
  end
endmodule

// File: rtl/guard_verdict.sv
module guard_verdict
  import guard_pkg::*;
#(
  parameter int NUM_RANGES = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  probe_t                probe,
  input  logic [NUM_RANGES-1:0] hit,
  input  logic [ADDR_W-1:0]     ctrl,
  input  logic [1:0]            clr,
  output logic                  rd_viol,
  output logic                  wr_viol,
  output logic [ADDR_W-1:0]     vaddr
);
  logic              any_hit, grant_rd, grant_wr, allowed, fire;
  logic              rd_d, wr_d, cap_we;
  logic [ADDR_W-1:0] vaddr_d;

  always_comb begin
    any_hit  = |hit;
    grant_wr = any_hit ? |(hit & ctrl[WR_LSB +: NUM_RANGES]) : ctrl[GWR_BIT];
    grant_rd = any_hit ? |(hit & ctrl[RD_LSB +: NUM_RANGES]) : ctrl[GRD_BIT];
    allowed  = probe.is_write ? grant_wr : grant_rd;

    rd_d     = rd_viol & ~clr[0];
    wr_d     = wr_viol & ~clr[1];
    fire     = probe.valid && ctrl[EN_BIT] && !allowed && !rd_d && !wr_d;
    cap_we   = fire;
    vaddr_d  = probe.addr;
    if (fire) begin
      rd_d = !probe.is_write;
      wr_d = probe.is_write;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_viol <= 1'b0;
      wr_viol <= 1'b0;
    end else begin
      rd_viol <= rd_d;
      wr_viol <= wr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vaddr <= '0;
    end else if (cap_we) begin
      vaddr <= vaddr_d;
    end
  end
endmodule

// File: rtl/addr_guard.sv
module addr_guard
  import guard_pkg::*;
#(
  parameter int NUM_RANGES = 6,
  parameter int CODE_MIN   = 9,
  parameter int CODE_MAX   = 21
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        acc_valid,
  input  logic        acc_write,
  input  logic [31:0] acc_addr,
  input  logic        cfg_we,
  input  logic [3:0]  cfg_sel,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  output logic        rd_viol,
  output logic        wr_viol
);
  localparam logic [3:0] SEL_VADDR = 4'(NUM_RANGES + 1);
  localparam logic [3:0] SEL_TEST  = 4'(NUM_RANGES + 2);

  logic [1:0]                          rst_pipe;
  logic                                rst_core_n;
  logic [ADDR_W-1:0]                   ctrl_q;
  logic [NUM_RANGES-1:0][BASE_W-1:0]   base_q;
  logic [NUM_RANGES-1:0][CODE_W-1:0]   code_q;
  logic [ADDR_W-1:0]                   vaddr_q;
  logic [NUM_RANGES-1:0]               hit;
  probe_t                              probe;
  logic [1:0]                          clr;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  always_comb begin
    probe = '0;
    if (acc_valid) begin
      probe.valid    = 1'b1;
      probe.is_write = acc_write;
      probe.addr     = acc_addr;
    end else if (cfg_we && (cfg_sel == SEL_TEST) && ctrl_q[TEST_BIT]) begin
      probe.valid    = 1'b1;
      probe.is_write = cfg_wdata[0];
      probe.addr     = {cfg_wdata[ADDR_W-1:2], 2'b00};
    end
    clr = (cfg_we && (cfg_sel == SEL_VADDR)) ? cfg_wdata[1:0] : 2'b00;
  end

  guard_regs #(.NUM_RANGES(NUM_RANGES), .SEL_W(4)) u_regs (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .cfg_wdata (cfg_wdata),
    .vaddr     (vaddr_q),
    .ctrl_q    (ctrl_q),
    .base_q    (base_q),
    .code_q    (code_q),
    .cfg_rdata (cfg_rdata)
  );

  for (genvar g = 0; g < NUM_RANGES; g++) begin : g_cmp
    guard_range_cmp #(.CODE_MIN(CODE_MIN), .CODE_MAX(CODE_MAX)) u_cmp (
      .addr (probe.addr),
      .base (base_q[g]),
      .code (code_q[g]),
      .hit  (hit[g])
    );
  end

  guard_verdict #(.NUM_RANGES(NUM_RANGES)) u_verdict (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .probe   (probe),
    .hit     (hit),
    .ctrl    (ctrl_q),
    .clr     (clr),
    .rd_viol (rd_viol),
    .wr_viol (wr_viol),
    .vaddr   (vaddr_q)
  );
endmodule

// File: rtl/addr_guard_chk.sv
module addr_guard_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        acc_valid,
  input logic        acc_write,
  input logic [31:0] acc_addr,
  input logic        cfg_we,
  input logic [3:0]  cfg_sel,
  input logic [31:0] cfg_wdata,
  input logic        rd_viol,
  input logic        wr_viol,
  input logic [31:0] vaddr_q,
  input logic        mon_en,
  input logic        test_en
);
  localparam logic [3:0] VSEL = 4'd7;
  localparam logic [3:0] TSEL = 4'd8;

  assert_one_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_viol, wr_viol}));

  assert_hold_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_viol || wr_viol) && !(cfg_we && cfg_sel == VSEL) |=> $stable(vaddr_q));

  assert_off_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !mon_en |=> !$rose(rd_viol) && !$rose(wr_viol));

  assert_rd_dir_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_viol) |-> $past(acc_valid ? !acc_write
                                       : (cfg_we && cfg_sel == TSEL && !cfg_wdata[0])));

  assert_wr_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_viol) |-> vaddr_q == $past(acc_valid ? acc_addr : {cfg_wdata[31:2], 2'b00}));

  assert_clear_rd_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && cfg_sel == VSEL && cfg_wdata[0] && !acc_valid |=> !rd_viol);

  assert_test_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && cfg_sel == TSEL && !test_en && !acc_valid && !rd_viol && !wr_viol
    |=> !rd_viol && !wr_viol);
endmodule

bind addr_guard addr_guard_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .acc_valid (acc_valid),
  .acc_write (acc_write),
  .acc_addr  (acc_addr),
  .cfg_we    (cfg_we),
  .cfg_sel   (cfg_sel),
  .cfg_wdata (cfg_wdata),
  .rd_viol   (rd_viol),
  .wr_viol   (wr_viol),
  .vaddr_q   (vaddr_q),
  .mon_en    (ctrl_q[31]),
  .test_en   (ctrl_q[30])
);

// File: tb/tb_addr_guard.sv
module tb_addr_guard;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0, acc_write = 1'b0;
  logic [31:0] acc_addr = '0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        rd_viol, wr_viol;

  int checks = 0, errors = 0;
  bit done = 0;

  // reference model state
  logic [31:0] m_ctrl = '0;
  logic [31:0] m_rng [6];
  bit          m_rd = 0, m_wr = 0;
  logic [31:0] m_va = '0;

  always #4 clk = ~clk;

  addr_guard dut (.*);

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic bit m_allow(logic [31:0] a, bit w);
    bit any = 0, ok = 0;
    for (int i = 0; i < 6; i++) begin
      int c = int'(m_rng[i][4:0]);
      if (c >= 9 && c <= 21) begin
        logic [31:0] msk = 32'hFFFF_FFFF << c;
        if (((a ^ m_rng[i]) & msk) == 0) begin
          any = 1;
          if (w ? m_ctrl[i] : m_ctrl[10+i]) ok = 1;
        end
      end
    end
    if (!any) ok = w ? m_ctrl[9] : m_ctrl[19];
    return ok;
  endfunction

  task automatic cycle(bit av, bit aw, logic [31:0] aa, bit we, logic [3:0] sel,
                       logic [31:0] wd, string tag);
    bit pv, pw; logic [31:0] pa; bit nrd, nwr;
    @(negedge clk);
    acc_valid = av; acc_write = aw; acc_addr = aa;
    cfg_we = we; cfg_sel = sel; cfg_wdata = wd;
    @(negedge clk);
    acc_valid = 0; cfg_we = 0;
    pv  = av || (we && sel == 4'd8 && m_ctrl[30]);
    pw  = av ? aw : wd[0];
    pa  = av ? aa : {wd[31:2], 2'b00};
    nrd = m_rd && !(we && sel == 4'd7 && wd[0]);
    nwr = m_wr && !(we && sel == 4'd7 && wd[1]);
    if (pv && m_ctrl[31] && !m_allow(pa, pw) && !nrd && !nwr) begin
      nrd = !pw; nwr = pw; m_va = pa;
    end
    m_rd = nrd; m_wr = nwr;
    if (we && sel == 4'd0) m_ctrl = wd & 32'hC008_FE3F;
    if (we && sel >= 4'd1 && sel <= 4'd6) m_rng[sel-1] = wd & 32'hFFFF_FE1F;
    cfg_sel = 4'd7;
    #1;
    check({tag, " rd_viol"}, {31'b0, rd_viol}, {31'b0, m_rd});
    check({tag, " wr_viol"}, {31'b0, wr_viol}, {31'b0, m_wr});
    check({tag, " vaddr"}, cfg_rdata, m_va);
  endtask

  task automatic rd_reg(logic [3:0] sel, logic [31:0] exp, string tag);
    @(negedge clk); cfg_sel = sel; #1;
    check(tag, cfg_rdata, exp);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 6; i++) m_rng[i] = '0;
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    check("R1 rd_viol", {31'b0, rd_viol}, 32'd0);
    check("R1 wr_viol", {31'b0, wr_viol}, 32'd0);
    for (int s = 0; s <= 8; s++) rd_reg(4'(s), 32'd0, "R1 reg reset");

    // R2: register field masking
    cycle(0, 0, 0, 1, 4'd0, 32'hFFFF_FFFF, "R2 ctrl write");
    rd_reg(4'd0, 32'hC008_FE3F, "R2 ctrl readback");
    cycle(0, 0, 0, 1, 4'd1, 32'h1234_5FFF, "R2 win write");
    rd_reg(4'd1, 32'h1234_5E1F, "R2 window readback");

    // R3/R4/R5: window 0 at 0x10000, 512 bytes, read+write permitted
    cycle(0, 0, 0, 1, 4'd0, 32'h8000_0401, "R4 ctrl");
    cycle(0, 0, 0, 1, 4'd1, 32'h0001_0009, "R3 win0");
    cycle(1, 0, 32'h0001_01FC, 0, 4'd0, 0, "R3 top of window");
    check("R3 inside allowed", {31'b0, rd_viol}, 32'd0);
    cycle(1, 0, 32'h0001_0200, 0, 4'd0, 0, "R5 read past window");
    check("R5 rd flag", {31'b0, rd_viol}, 32'd1);
    check("R5 captured", cfg_rdata, 32'h0001_0200);
    // R6: second offence not recorded
    cycle(1, 1, 32'h0000_0000, 0, 4'd0, 0, "R6 second");
    check("R6 wr stays low", {31'b0, wr_viol}, 32'd0);
    check("R6 addr held", cfg_rdata, 32'h0001_0200);
    // R7: clear only wr bit leaves rd; then clear rd
    cycle(0, 0, 0, 1, 4'd7, 32'h2, "R7 clear wr only");
    check("R7 rd kept", {31'b0, rd_viol}, 32'd1);
    cycle(0, 0, 0, 1, 4'd7, 32'h1, "R7 clear rd");
    check("R7 rd cleared", {31'b0, rd_viol}, 32'd0);

    // R3: code 21 ignores low base bits; write perm on window 1
    cycle(0, 0, 0, 1, 4'd2, 32'h00A1_2015, "R3 win1 2MB");
    cycle(0, 0, 0, 1, 4'd0, 32'h8000_0403, "R4 ctrl");
    cycle(1, 1, 32'h00BF_FFFC, 0, 4'd0, 0, "R3 2MB upper end");
    check("R3 2MB allowed", {31'b0, wr_viol}, 32'd0);
    cycle(1, 1, 32'h00C0_0000, 0, 4'd0, 0, "R3 2MB beyond");
    check("R3 beyond flagged", {31'b0, wr_viol}, 32'd1);
    cycle(0, 0, 0, 1, 4'd7, 32'h3, "R7 clear both");

    // R3: code 0 and code 8 match nothing even with perms; R4 global read
    cycle(0, 0, 0, 1, 4'd3, 32'h0002_0000, "R3 code0");
    cycle(0, 0, 0, 1, 4'd4, 32'h0003_0008, "R3 code8");
    cycle(0, 0, 0, 1, 4'd0, 32'h8000_FC3F, "R4 all window perms");
    cycle(1, 0, 32'h0002_0000, 0, 4'd0, 0, "R3 code0 no grant");
    check("R3 code0 flagged", {31'b0, rd_viol}, 32'd1);
    cycle(0, 0, 0, 1, 4'd7, 32'h1, "R7 clear");
    cycle(1, 0, 32'h0003_0000, 0, 4'd0, 0, "R3 code8 no grant");
    check("R3 code8 flagged", {31'b0, rd_viol}, 32'd1);
    cycle(0, 0, 0, 1, 4'd7, 32'h1, "R7 clear");
    cycle(0, 0, 0, 1, 4'd0, 32'h8008_0000, "R4 global read only");
    cycle(1, 0, 32'h7000_0000, 0, 4'd0, 0, "R4 global read");
    check("R4 global read ok", {31'b0, rd_viol}, 32'd0);
    cycle(1, 1, 32'h7000_0000, 0, 4'd0, 0, "R4 global write off");
    check("R4 global write off", {31'b0, wr_viol}, 32'd1);
    cycle(0, 0, 0, 1, 4'd7, 32'h2, "R7 clear");

    // R4: overlap, window 2 denies, window 3 grants read
    cycle(0, 0, 0, 1, 4'd3, 32'h0005_000A, "R4 win2");
    cycle(0, 0, 0, 1, 4'd4, 32'h0005_000A, "R4 win3");
    cycle(0, 0, 0, 1, 4'd0, 32'h8000_2000, "R4 only win3 read");
    cycle(1, 0, 32'h0005_0100, 0, 4'd0, 0, "R4 overlap");
    check("R4 overlap allowed", {31'b0, rd_viol}, 32'd0);

    // R8: disabled
    cycle(0, 0, 0, 1, 4'd0, 32'h0000_0000, "R8 disable");
    cycle(1, 1, 32'h0BAD_0000, 0, 4'd0, 0, "R8 silent");
    check("R8 no flag", {31'b0, wr_viol}, 32'd0);
    check("R8 addr unchanged", cfg_rdata, 32'h7000_0000);

    // R9: test write ignored without test bit, works with it, bus wins
    cycle(0, 0, 0, 1, 4'd0, 32'h8000_0000, "R9 en only");
    cycle(0, 0, 0, 1, 4'd8, 32'h00C0_0001, "R9 test off");
    check("R9 ignored", {31'b0, wr_viol}, 32'd0);
    cycle(0, 0, 0, 1, 4'd0, 32'hC008_0000, "R9 test on");
    cycle(1, 0, 32'h1000_0000, 1, 4'd8, 32'h00C0_0001, "R9 bus wins");
    check("R9 bus precedence", {31'b0, wr_viol}, 32'd0);
    cycle(0, 0, 0, 1, 4'd8, 32'h00C0_0003, "R9 inject");
    check("R9 injected flag", {31'b0, wr_viol}, 32'd1);
    check("R9 injected addr", cfg_rdata, 32'h00C0_0000);
    cycle(0, 0, 0, 1, 4'd7, 32'h3, "R7 clear");

    // random phase
    for (int it = 0; it < 3000; it++) begin
      int r = $urandom % 100;
      if (it % 60 == 0) begin
        for (int w = 0; w < 6; w++) begin
          logic [31:0] d = $urandom & 32'h00FF_FFFF;
          int k = $urandom % 20;
          d[4:0] = (k < 2) ? 5'($urandom % 32) : (k < 4) ? 5'd0 : 5'(9 + $urandom % 13);
          cycle(0, 0, 0, 1, 4'(w + 1), d, "R3 rand window");
        end
        begin
          logic [31:0] c = $urandom;
          c[31] = ($urandom % 8) != 0;
          cycle(0, 0, 0, 1, 4'd0, c, "R4 rand ctrl");
        end
      end
      if ((m_rd || m_wr) && r < 25) begin
        cycle(($urandom % 2) == 1, $urandom % 2, $urandom & 32'h00FF_FFFC,
              1, 4'd7, $urandom, "R7 rand clear");
      end else if (r < 35) begin
        cycle(0, 0, 0, 1, 4'd8, $urandom & 32'h00FF_FFFF, "R9 rand test");
      end else begin
        int i = $urandom % 6;
        int c = int'(m_rng[i][4:0]);
        logic [31:0] a;
        if (c >= 9 && c <= 21)
          a = (m_rng[i] & (32'hFFFF_FFFF << c)) + ($urandom % (32'd1 << (c + 1)));
        else
          a = $urandom & 32'h00FF_FFFF;
        cycle(1, $urandom % 2, a & 32'hFFFF_FFFC, 0, 4'd0, 0, "R5 rand access");
      end
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule